// File: doc/BRIEF.md
# Clock-Tick Interrupt Event Emulator

This block rebuilds the three interrupt sources of a time-of-day clock from a steady 64 Hz tick supplied by a free-running timer channel. The three sources are once-per-second update, alarm and periodic events. The block owns the comparator value of that channel and drives it out on `cmp_o`. On every tick it first moves the comparator forward by one tick interval. If the counter has already passed the new value, the block keeps advancing the comparator, one interval per clock, and counts each extra step as a lost tick.

When the comparator is ahead of the counter again, the block evaluates the events. The update check compares the current second with the second seen on the previous evaluation. The alarm check compares hour, minute and second with the stored alarm time. The periodic path runs a divider that has already been credited with the lost ticks. If any event fires, the block emits a one-cycle flag word together with a valid strobe.

The tick channel is enabled only while at least one event source is enabled. When the first source is switched on after all were off, the block reloads the comparator one interval ahead of the counter. Time-of-day keeping happens outside this block.

Top module: `rtc_irq_emu`

## Requirements
- R1: `chan_en_o` is high exactly while at least one of `upd_en_i`, `alm_en_i`, `per_en_i` is high. A tick that arrives while all three are low produces no flag word and leaves `cmp_o` unchanged.
- R2: On the clock edge where the enables go from all low to any high, `cmp_o` loads `counter_i + TICK_DELTA`.
- R3: A tick accepted while idle adds `TICK_DELTA` to `cmp_o`. While `$signed(counter_i - cmp_o) > 0`, the block adds `TICK_DELTA` again on each following clock. Every such extra step counts as one lost tick.
- R4: Periodic divide limit: for `rate_i` = 2^k with 2^k below `BASE_HZ` (64), the limit is `BASE_HZ / 2^k`. For rates at or above 64 the limit is 1. A rate of 0 is treated as 1 Hz. For a rate that is not a power of two, its highest set bit sets the limit.
- R5: With the periodic source enabled, each evaluation adds 1 plus the lost-tick count to the periodic count. When the count reaches the limit, bit 6 of the word is set and the count returns to zero.
- R6: With the update source enabled, bit 4 is set when `sec_i` differs from the second stored at the previous evaluation. That second is then stored.
- R7: After `upd_en_i` rises, the first evaluation only stores the second and sets no bit 4, even if the second has changed.
- R8: With the alarm source enabled, bit 5 is set when hour, minute and second all equal `alm_hour_i`, `alm_min_i` and `alm_sec_i`.
- R9: When any of bits 4..6 is set, the word also sets bit 7 and carries the value 1 in bits 15:8. The word is driven for exactly one cycle with `flags_valid_o`. Otherwise `flags_o` is zero and no strobe is given.
- R10: `flags_valid_o` rises after the clock edge that comes 2 + L edges after the edge that accepted the tick, where L is the lost-tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Comparator match pulse from the timer channel |
| counter_i | input | CNT_W | Free-running counter value of the timer |
| hour_i | input | HR_W | Current hour |
| min_i | input | MS_W | Current minute |
| sec_i | input | MS_W | Current second |
| upd_en_i | input | 1 | Update source enable |
| alm_en_i | input | 1 | Alarm source enable |
| per_en_i | input | 1 | Periodic source enable |
| alm_hour_i | input | HR_W | Alarm hour |
| alm_min_i | input | MS_W | Alarm minute |
| alm_sec_i | input | MS_W | Alarm second |
| rate_i | input | RATE_W | Requested periodic rate in Hz |
| chan_en_o | output | 1 | Tick channel enable |
| cmp_o | output | CNT_W | Comparator value for the tick channel |
| flags_o | output | FLAG_W | Event flag word |
| flags_valid_o | output | 1 | Flag word strobe |

## Verification
The assertions assume three things about the inputs. The time inputs stay still between an accepted tick and its evaluation. `tick_i` is not raised while a catch-up walk is in progress. Enables do not change during the evaluation cycle. The bench keeps within these rules in two ways. It holds `counter_i` and the time inputs fixed while it raises a one-cycle tick and waits out the full catch-up window. It changes enables only between ticks, with idle cycles around each change. Its random stimulus sets the counter so that zero to three ticks are lost, uses power-of-two rates and rates above 64, and forces alarm matches often enough to reach every flag combination.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
  localparam int FLAG_W   = 16;
  localparam int UF_BIT   = 4;
  localparam int AF_BIT   = 5;
  localparam int PF_BIT   = 6;
  localparam int IRQF_BIT = 7;
  localparam int NUM_LSB  = 8;

  typedef struct packed {
    logic upd;
    logic alm;
    logic per;
  } src_en_t;
endpackage

// File: rtl/rtc_catchup.sv
module rtc_catchup #(
  parameter int CNT_W      = 32,
  parameter int LOST_W     = 8,
  parameter int TICK_DELTA = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [CNT_W-1:0]  counter_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [LOST_W-1:0] lost_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] DELTA = CNT_W'(TICK_DELTA);

  logic busy_q;
  logic behind;

  // counter already past comparator: signed distance positive
  assign behind = $signed(counter_i - cmp_o) > 0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o  <= '0;
      lost_o <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else if (restart_i) begin
      cmp_o  <= counter_i + DELTA;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else if (!run_i) begin
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else if (!busy_q) begin
      done_o <= 1'b0;
      if (tick_i) begin
        cmp_o  <= cmp_o + DELTA;
        lost_o <= '0;
        busy_q <= 1'b1;
      end
    end else if (behind) begin
      cmp_o <= cmp_o + DELTA;
      if (lost_o != '1) lost_o <= lost_o + 1'b1;
    end else begin
      busy_q <= 1'b0;
      done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_event_eval.sv
module rtc_event_eval
  import rtc_emu_pkg::*;
#(
  parameter int HR_W    = 5,
  parameter int MS_W    = 6,
  parameter int RATE_W  = 14,
  parameter int LOST_W  = 8,
  parameter int BASE_HZ = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  src_en_t           en_i,
  input  logic              upd_rise_i,
  input  logic [HR_W-1:0]   hour_i,
  input  logic [MS_W-1:0]   min_i,
  input  logic [MS_W-1:0]   sec_i,
  input  logic [HR_W-1:0]   alm_hour_i,
  input  logic [MS_W-1:0]   alm_min_i,
  input  logic [MS_W-1:0]   alm_sec_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [LOST_W-1:0] lost_i,
  output logic [FLAG_W-1:0] word_o,
  output logic              valid_o
);
  localparam int BASE_LOG = $clog2(BASE_HZ);
  localparam int PCNT_W   = BASE_LOG + 1;
  localparam int SUM_W    = PCNT_W + LOST_W + 1;

  function automatic logic [PCNT_W-1:0] div_limit(input logic [RATE_W-1:0] r);
    int msb;
    msb = 0;
    for (int i = 0; i < RATE_W; i++) if (r[i]) msb = i;
    if (msb >= BASE_LOG) return PCNT_W'(1);
    return PCNT_W'(BASE_HZ >> msb);
  endfunction

  logic [MS_W-1:0]   prev_sec_q;
  logic              prev_vld_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [SUM_W-1:0]  pcnt_sum;
  logic [PCNT_W-1:0] limit;
  logic              uf, af, pf, sec_new;
  logic [FLAG_W-1:0] word_d;

  always_comb begin
    limit    = div_limit(rate_i);
    pcnt_sum = SUM_W'(pcnt_q) + SUM_W'(lost_i) + SUM_W'(1);
    sec_new  = !prev_vld_q || (sec_i != prev_sec_q);
    uf       = en_i.upd && prev_vld_q && (sec_i != prev_sec_q);
    pf       = en_i.per && (pcnt_sum >= SUM_W'(limit));
    af       = en_i.alm && (hour_i == alm_hour_i) && (min_i == alm_min_i) &&
               (sec_i == alm_sec_i);
    word_d   = '0;
    word_d[UF_BIT] = uf;
    word_d[AF_BIT] = af;
    word_d[PF_BIT] = pf;
    if (uf || af || pf) begin
      word_d[IRQF_BIT] = 1'b1;
      word_d[FLAG_W-1:NUM_LSB] = (FLAG_W-NUM_LSB)'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_sec_q <= '0;
      prev_vld_q <= 1'b0;
      pcnt_q     <= '0;
      word_o     <= '0;
      valid_o    <= 1'b0;
    end else begin
      if (upd_rise_i) begin
        prev_vld_q <= 1'b0;
      end else if (eval_i && en_i.upd && sec_new) begin
        prev_sec_q <= sec_i;
        prev_vld_q <= 1'b1;
      end
      if (eval_i && en_i.per) pcnt_q <= pf ? '0 : pcnt_sum[PCNT_W-1:0];
      if (eval_i && (uf || af || pf)) begin
        word_o  <= word_d;
        valid_o <= 1'b1;
      end else begin
        word_o  <= '0;
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu
  import rtc_emu_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int HR_W       = 5,
  parameter int MS_W       = 6,
  parameter int RATE_W     = 14,
  parameter int LOST_W     = 8,
  parameter int BASE_HZ    = 64,
  parameter int TICK_DELTA = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  counter_i,
  input  logic [HR_W-1:0]   hour_i,
  input  logic [MS_W-1:0]   min_i,
  input  logic [MS_W-1:0]   sec_i,
  input  logic              upd_en_i,
  input  logic              alm_en_i,
  input  logic              per_en_i,
  input  logic [HR_W-1:0]   alm_hour_i,
  input  logic [MS_W-1:0]   alm_min_i,
  input  logic [MS_W-1:0]   alm_sec_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              chan_en_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              flags_valid_o
);
  src_en_t           en, en_q;
  logic              any_q, restart, upd_rise, done;
  logic [LOST_W-1:0] lost;

  assign en        = '{upd: upd_en_i, alm: alm_en_i, per: per_en_i};
  assign chan_en_o = |en;
  assign restart   = chan_en_o && !any_q;
  assign upd_rise  = en.upd && !en_q.upd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      any_q <= 1'b0;
    end else begin
      en_q  <= en;
      any_q <= chan_en_o;
    end
  end

  rtc_catchup #(
    .CNT_W(CNT_W), .LOST_W(LOST_W), .TICK_DELTA(TICK_DELTA)
  ) u_catchup (
    .clk_i, .rst_ni, .tick_i,
    .run_i(chan_en_o), .restart_i(restart), .counter_i,
    .cmp_o, .lost_o(lost), .done_o(done)
  );

  rtc_event_eval #(
    .HR_W(HR_W), .MS_W(MS_W), .RATE_W(RATE_W), .LOST_W(LOST_W), .BASE_HZ(BASE_HZ)
  ) u_eval (
    .clk_i, .rst_ni, .eval_i(done), .en_i(en), .upd_rise_i(upd_rise),
    .hour_i, .min_i, .sec_i, .alm_hour_i, .alm_min_i, .alm_sec_i,
    .rate_i, .lost_i(lost), .word_o(flags_o), .valid_o(flags_valid_o)
  );
endmodule

// File: rtl/rtc_irq_emu_chk.sv
module rtc_irq_emu_chk #(
  parameter int CNT_W      = 32,
  parameter int HR_W       = 5,
  parameter int MS_W       = 6,
  parameter int TICK_DELTA = 100
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] counter_i,
  input logic [HR_W-1:0]  hour_i,
  input logic [MS_W-1:0]  min_i,
  input logic [MS_W-1:0]  sec_i,
  input logic             upd_en_i,
  input logic             alm_en_i,
  input logic             per_en_i,
  input logic [HR_W-1:0]  alm_hour_i,
  input logic [MS_W-1:0]  alm_min_i,
  input logic [MS_W-1:0]  alm_sec_i,
  input logic             chan_en_o,
  input logic [CNT_W-1:0] cmp_o,
  input logic [15:0]      flags_o,
  input logic             flags_valid_o
);
  a_r9_word_format: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_valid_o |-> flags_o[7] && flags_o[15:8] == 8'd1 && (|flags_o[6:4]));
  a_r9_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_valid_o |=> !flags_valid_o);
  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_valid_o |-> flags_o == 16'd0);
  a_r1_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_o |=> !flags_valid_o);
  a_r1_cmp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_o |=> $stable(cmp_o));
  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chan_en_o) |=> cmp_o == $past(counter_i) + CNT_W'(TICK_DELTA));
  a_r6_upd_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[4] |-> $past(upd_en_i));
  a_r5_per_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[6] |-> $past(per_en_i));
  a_r8_alarm_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[5] |-> $past(alm_en_i) && $past(hour_i == alm_hour_i) &&
                   $past(min_i == alm_min_i) && $past(sec_i == alm_sec_i));
endmodule

bind rtc_irq_emu rtc_irq_emu_chk #(
  .CNT_W(CNT_W), .HR_W(HR_W), .MS_W(MS_W), .TICK_DELTA(TICK_DELTA)
) u_chk (
  .clk_i, .rst_ni, .counter_i, .hour_i, .min_i, .sec_i,
  .upd_en_i, .alm_en_i, .per_en_i, .alm_hour_i, .alm_min_i, .alm_sec_i,
  .chan_en_o, .cmp_o, .flags_o, .flags_valid_o
);

// File: tb/tb_rtc_irq_emu.sv
module tb_rtc_irq_emu;
  localparam int D = 100;

  logic        clk = 0, rst_n = 0, tick = 0;
  logic [31:0] counter = 0;
  logic [4:0]  hour = 0, a_hour = 0;
  logic [5:0]  min = 0, sec = 0, a_min = 0, a_sec = 0;
  logic        upd = 0, alm = 0, per = 0;
  logic [13:0] rate = 1;
  logic        chan_en, fvalid;
  logic [31:0] cmp;
  logic [15:0] flags;

  rtc_irq_emu dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .counter_i(counter),
    .hour_i(hour), .min_i(min), .sec_i(sec),
    .upd_en_i(upd), .alm_en_i(alm), .per_en_i(per),
    .alm_hour_i(a_hour), .alm_min_i(a_min), .alm_sec_i(a_sec), .rate_i(rate),
    .chan_en_o(chan_en), .cmp_o(cmp), .flags_o(flags), .flags_valid_o(fvalid)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, vcount = 0, vcyc = 0;
  logic [15:0] vword;
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (fvalid) begin vcount++; vword = flags; vcyc = cyc; end

  // reference model state
  logic [31:0] m_cmp = 0;
  bit   m_pv = 0;
  logic [5:0] m_ps = 0;
  int   m_pc = 0;

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lim(int r);
    if (r >= 64) return 1;
    if (r == 0) return 64;
    return 64 / r;
  endfunction

  task automatic set_en(bit u, bit a, bit p);
    @(negedge clk);
    if (!(upd || alm || per) && (u || a || p)) m_cmp = counter + D;
    if (u && !upd) m_pv = 0;
    upd = u; alm = a; per = p;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_tick(string req);
    logic [15:0] f;
    int lost, c0;
    f = 0; lost = 0;
    if (upd || alm || per) begin
      m_cmp += D;
      while ($signed(counter - m_cmp) > 0) begin m_cmp += D; lost++; end
      if (upd && (!m_pv || sec != m_ps)) begin
        if (m_pv) f[4] = 1;
        m_ps = sec; m_pv = 1;
      end
      if (per) begin
        m_pc += 1 + lost;
        if (m_pc >= lim(int'(rate))) begin f[6] = 1; m_pc = 0; end
      end
      if (alm && hour == a_hour && min == a_min && sec == a_sec) f[5] = 1;
      if (f != 0) begin f[7] = 1; f[15:8] = 8'd1; end
    end
    @(negedge clk);
    vcount = 0; tick = 1; c0 = cyc;
    @(negedge clk);
    tick = 0;
    repeat (lost + 6) @(negedge clk);
    if (f != 0) begin
      chk({req, " R9 one strobe"}, vcount, 1);
      chk({req, " R9 word"}, vword, f);
      chk({req, " R10 latency"}, vcyc, c0 + 3 + lost);
    end else begin
      chk({req, " R9 no word"}, vcount, 0);
    end
    chk({req, " R3 cmp"}, cmp, m_cmp);
  endtask

  // counter placed so that 'lag' extra steps are needed
  task automatic lag_to(int lag);
    @(negedge clk);
    counter = m_cmp + D + lag * D - ((lag > 0) ? 1 : 0);
    if (lag == 0) counter = m_cmp + 10;
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 reset chan", chan_en, 0);
    chk("R9 reset valid", fvalid, 0);
    chk("R9 reset flags", flags, 0);
    chk("R1 reset cmp", cmp, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: tick with everything off is ignored
    counter = 32'd5000;
    do_tick("R1 off");
    chk("R1 cmp unchanged", cmp, 0);
    chk("R1 chan off", chan_en, 0);

    // R2: restart on first enable
    set_en(1, 0, 0);
    chk("R2 restart cmp", cmp, 32'd5000 + D);
    chk("R1 chan on", chan_en, 1);

    // R7: first evaluation after enabling suppresses update
    sec = 6'd10; lag_to(0);
    do_tick("R7 first");
    sec = 6'd10; lag_to(0);
    do_tick("R6 same sec");
    sec = 6'd11; lag_to(0);
    do_tick("R6 sec change");
    chk("R6 uf bit", vword[4], 1);

    // R8: alarm
    set_en(0, 1, 0);
    hour = 5'd3; min = 6'd4; sec = 6'd5;
    a_hour = 5'd3; a_min = 6'd4; a_sec = 6'd5;
    lag_to(0); do_tick("R8 match");
    chk("R8 af bit", vword[5], 1);
    min = 6'd9; lag_to(0); do_tick("R8 minute off");

    // R4/R5: periodic divide by 4 at 16 Hz
    set_en(0, 0, 1);
    rate = 14'd16;
    for (int i = 0; i < 8; i++) begin lag_to(0); do_tick("R5 div4"); end
    rate = 14'd128;
    lag_to(0); do_tick("R4 fast rate");
    chk("R4 every tick", vword[6], 1);

    // R3/R5: lost ticks credited to periodic count
    rate = 14'd8;
    lag_to(3); do_tick("R3 lag3");
    lag_to(2); do_tick("R3 lag2");
    lag_to(5); do_tick("R5 lag5 fires");
    chk("R5 lost credit", vword[6], 1);

    // R7: re-enabling update resets the previous second
    set_en(0, 0, 0);
    lag_to(0); do_tick("R1 off again");
    sec = 6'd30; set_en(1, 0, 1);
    lag_to(0); do_tick("R7 reenable");
    sec = 6'd31; lag_to(1); do_tick("R6 after reenable");

    // random phase
    for (int it = 0; it < 300; it++) begin
      if ($urandom_range(0, 9) == 0)
        set_en(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      @(negedge clk);
      rate = 14'(1 << $urandom_range(0, 8));
      hour = 5'($urandom_range(0, 2));
      min  = 6'($urandom_range(0, 2));
      if ($urandom_range(0, 2) == 0) sec = sec + 6'd1;
      if ($urandom_range(0, 3) == 0) begin a_hour = hour; a_min = min; a_sec = sec; end
      lag_to($urandom_range(0, 3));
      do_tick("R5 random");
    end

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule